// File: doc/BRIEF.md
# Biphase Mark Timecode Frame Encoder

This block turns one linear-timecode frame into a one-bit biphase-mark line level. The source hands over a 64-bit data word through a valid/ready handshake. The encoder appends the fixed 16-bit sync pattern and shifts out all 80 bit-cells, least significant bit first. The line level is updated twice per bit-cell, once for each half-cell.

The half-cell tick comes from a divider of the system clock. A 2-bit rate select sets the cell rate to 80 times the chosen frame rate. The rate is captured when each frame starts. Ready rises during the last cell of a frame, so a frame loaded then follows the current one with no gap. The line polarity is never reset between frames. While no frame is pending the line holds its level.

Top module: `tc_bmc_encoder`

## Requirements
- R1: After reset, line_out is low and frame_ready is high.
- R2: A frame is 80 cells. Cells 0 to 63 carry frame_data bits 0 to 63 in that order. Cells 64 to 79 carry the sync value 16'h3FFD, least significant bit first: 1,0,1,1,1,1,1,1,1,1,1,1,1,1,0,0.
- R3: line_out inverts at the start of every cell, whatever the cell's bit value.
- R4: A cell holding 1 inverts line_out again at mid-cell. A cell holding 0 keeps the same level in both halves.
- R5: Each half-cell lasts CLK_HZ/(fps*160) clock cycles. rate_sel 00 gives 24 fps, 01 gives 25 fps and 10 gives 30 fps. Code 11 falls back to 30 fps.
- R6: rate_sel is sampled on the edge where a frame starts. Changing it during a frame does not alter that frame's timing.
- R7: A frame accepted on a clock edge starts on the following edge, where its first cell-start inversion appears.
- R8: frame_ready is low from acceptance until the last cell of the running frame and high for the whole of cell 79. A frame accepted during cell 79 starts on the edge that ends the previous frame, with no gap.
- R9: The line level carries over from one frame to the next. The first cell of a frame inverts whatever level the previous frame left.
- R10: With no frame pending after a frame ends, line_out holds its level and frame_ready stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_sel | input | 2 | Frame rate code (00=24, 01=25, 10=30, 11=30 fps) |
| frame_valid | input | 1 | frame_data holds a frame to send |
| frame_data | input | 64 | Timecode data bits, bit 0 sent first |
| frame_ready | output | 1 | Encoder can accept a frame this cycle |
| line_out | output | 1 | Biphase-mark line level |

## Verification
The bench samples the line once per half-cell, exactly at the edge where each transition is due. A start edge that is one cycle late, a misplaced divider limit or a wrong rate code changes the level at one of those sample points. A design that cleared the polarity at frame start, or failed to invert on the first cell after an idle gap, shows the wrong level in the first half-cell of the following frame. Ready is probed just before and during the last cell, and a second frame is loaded there; a design that left a gap or dropped the frame would play the wrong bits. The rate input is changed in the middle of a frame, and a design that failed to hold the rate per frame would stretch the remaining cells.

// File: rtl/tc_bmc_pkg.sv
`timescale 1ns/1ps
package tc_bmc_pkg;
  localparam int unsigned FRAME_CELLS = 80;
  localparam int unsigned DATA_BITS   = 64;
  localparam int unsigned SYNC_BITS   = FRAME_CELLS - DATA_BITS;
  localparam int unsigned IDX_W       = $clog2(FRAME_CELLS);
  localparam logic [SYNC_BITS-1:0] SYNC_PATTERN = 16'h3FFD;

  typedef enum logic [1:0] {
    RATE_24 = 2'b00,
    RATE_25 = 2'b01,
    RATE_30 = 2'b10
  } rate_e;

  // Frame rate for a select code; unknown codes fall back to 30.
  function automatic int unsigned fps_of(input logic [1:0] sel);
    case (sel)
      RATE_24: return 24;
      RATE_25: return 25;
      default: return 30;
    endcase
  endfunction

  // Clock cycles per half-cell: two halves per cell, FRAME_CELLS cells per frame.
  function automatic int unsigned half_cell_cycles(input int unsigned clk_hz,
                                                   input logic [1:0] sel);
    return clk_hz / (fps_of(sel) * FRAME_CELLS * 2);
  endfunction
endpackage

// File: rtl/tc_halfcell_div.sv
`timescale 1ns/1ps
module tc_halfcell_div
  import tc_bmc_pkg::*;
#(
  parameter int unsigned CLK_HZ = 48_000_000,
  parameter int unsigned DIV_W  = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] rate,
  output logic       tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] limit;

  always_comb limit = DIV_W'(half_cell_cycles(CLK_HZ, rate));

  assign tick = run && (cnt_q == limit - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run || restart || tick) cnt_q <= '0;
    else                                   cnt_q <= cnt_q + DIV_W'(1);
  end

  // R5
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/tc_frame_seq.sv
`timescale 1ns/1ps
module tc_frame_seq
  import tc_bmc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_valid,
  input  logic [DATA_BITS-1:0] load_data,
  input  logic                 tick,
  output logic                 load_ready,
  output logic                 active,
  output logic                 start_evt,
  output logic                 cell_evt,
  output logic                 mid_evt,
  output logic                 cur_bit
);
  logic [FRAME_CELLS-1:0] shreg_q;
  logic [IDX_W-1:0]       bit_idx_q;
  logic                   half_q;
  logic                   active_q;
  logic                   pend_v_q;
  logic [DATA_BITS-1:0]   pend_q;
  logic                   last_cell;
  logic                   frame_end;
  logic                   next_cell;
  logic                   accept;

  assign last_cell  = active_q && (bit_idx_q == IDX_W'(FRAME_CELLS - 1));
  assign frame_end  = tick && half_q && last_cell;
  assign next_cell  = tick && half_q && !last_cell;
  assign mid_evt    = tick && !half_q;
  assign start_evt  = pend_v_q && (!active_q || frame_end);
  assign cell_evt   = start_evt || next_cell;
  assign load_ready = !pend_v_q && (!active_q || last_cell);
  assign accept     = load_valid && load_ready;
  assign active     = active_q;
  assign cur_bit    = shreg_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v_q <= 1'b0;
      pend_q   <= '0;
    end else if (accept) begin
      pend_v_q <= 1'b1;
      pend_q   <= load_data;
    end else if (start_evt) begin
      pend_v_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg_q   <= '0;
      bit_idx_q <= '0;
      half_q    <= 1'b0;
      active_q  <= 1'b0;
    end else if (start_evt) begin
      shreg_q   <= {SYNC_PATTERN, pend_q};
      bit_idx_q <= '0;
      half_q    <= 1'b0;
      active_q  <= 1'b1;
    end else if (frame_end) begin
      active_q  <= 1'b0;
      half_q    <= 1'b0;
    end else if (next_cell) begin
      shreg_q   <= {1'b0, shreg_q[FRAME_CELLS-1:1]};
      bit_idx_q <= bit_idx_q + IDX_W'(1);
      half_q    <= 1'b0;
    end else if (mid_evt) begin
      half_q    <= 1'b1;
    end
  end

  // R2
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_idx_q < IDX_W'(FRAME_CELLS));

  // R2
  sync_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && bit_idx_q >= IDX_W'(DATA_BITS)) |->
      (cur_bit == SYNC_PATTERN[4'(bit_idx_q - IDX_W'(DATA_BITS))]));

  // R8
  gapless_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && pend_v_q) |=> (active_q && bit_idx_q == '0));
endmodule

// File: rtl/tc_bmc_line.sv
`timescale 1ns/1ps
module tc_bmc_line (
  input  logic clk,
  input  logic rst_n,
  input  logic cell_evt,
  input  logic mid_evt,
  input  logic cur_bit,
  output logic line
);
  logic line_q;
  logic flip;

  assign flip = cell_evt || (mid_evt && cur_bit);
  assign line = line_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    line_q <= 1'b0;
    else if (flip) line_q <= ~line_q;
  end
endmodule

// File: rtl/tc_bmc_encoder.sv
`timescale 1ns/1ps
module tc_bmc_encoder
  import tc_bmc_pkg::*;
#(
  parameter int unsigned CLK_HZ = 48_000_000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           rate_sel,
  input  logic                 frame_valid,
  input  logic [DATA_BITS-1:0] frame_data,
  output logic                 frame_ready,
  output logic                 line_out
);
  localparam int unsigned MAX_DIV = half_cell_cycles(CLK_HZ, RATE_24);
  localparam int unsigned DIV_W   = $clog2(MAX_DIV + 1);

  logic       tick;
  logic       active;
  logic       start_evt;
  logic       cell_evt;
  logic       mid_evt;
  logic       cur_bit;
  logic [1:0] rate_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         rate_q <= RATE_30;
    else if (start_evt) rate_q <= rate_sel;
  end

  tc_halfcell_div #(.CLK_HZ(CLK_HZ), .DIV_W(DIV_W)) div_i (
    .clk(clk), .rst_n(rst_n), .run(active), .restart(start_evt),
    .rate(rate_q), .tick(tick)
  );

  tc_frame_seq seq_i (
    .clk(clk), .rst_n(rst_n), .load_valid(frame_valid), .load_data(frame_data),
    .tick(tick), .load_ready(frame_ready), .active(active), .start_evt(start_evt),
    .cell_evt(cell_evt), .mid_evt(mid_evt), .cur_bit(cur_bit)
  );

  tc_bmc_line line_i (
    .clk(clk), .rst_n(rst_n), .cell_evt(cell_evt), .mid_evt(mid_evt),
    .cur_bit(cur_bit), .line(line_out)
  );

  // R3
  cell_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_evt |=> (line_out != $past(line_out)));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !start_evt) |=> $stable(line_out));

  // R6
  rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !start_evt) |=> $stable(rate_q));
endmodule

// File: tb/tc_bmc_encoder_tb_top.sv
`timescale 1ns/1ps
module tc_bmc_encoder_tb_top;
  localparam int unsigned TB_CLK_HZ = 96000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  rate_sel = 2'b10;
  logic        frame_valid = 1'b0;
  logic [63:0] frame_data = '0;
  logic        frame_ready;
  logic        line_out;

  int checks = 0;
  int fails = 0;
  logic lvl = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tc_bmc_encoder #(.CLK_HZ(TB_CLK_HZ)) dut_i (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .frame_valid(frame_valid),
    .frame_data(frame_data), .frame_ready(frame_ready), .line_out(line_out)
  );

  function automatic int unsigned halves_for(input logic [1:0] sel);
    int unsigned f;
    f = (sel == 2'b00) ? 24 : (sel == 2'b01) ? 25 : 30;
    return TB_CLK_HZ / (2 * 80 * f);
  endfunction

  function automatic logic cell_bit(input logic [63:0] d, input int i);
    logic [15:0] sw;
    sw = 16'h3FFD;
    if (i < 64) return d[i];
    return sw[i-64];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Sampling starts at the falling edge right after the frame's start edge.
  task automatic play_frame(input logic [63:0] d, input int unsigned div,
                            input bit inject, input logic [63:0] nd,
                            input bit poke_rate, input logic [1:0] new_rate);
    int errs = 0;
    int first = -1;
    logic first_act = 1'b0;
    for (int i = 0; i < 80; i++) begin
      for (int h = 0; h < 2; h++) begin
        if (!(i == 0 && h == 0)) begin
          if (i == 79 && h == 1 && inject) repeat (div - 1) @(negedge clk);
          else repeat (div) @(negedge clk);
        end
        if (h == 0) lvl = ~lvl;
        else if (cell_bit(d, i)) lvl = ~lvl;
        if (line_out !== lvl) begin
          errs++;
          if (first < 0) begin first = 2 * i + h; first_act = line_out; end
        end
        if (i == 10 && h == 0 && poke_rate) rate_sel = new_rate;
        if (i == 78 && h == 1)
          check(frame_ready === 1'b0, "R8", "ready before last cell", frame_ready, 0);
        if (i == 79 && h == 0) begin
          check(frame_ready === 1'b1, "R8", "ready in last cell", frame_ready, 1);
          if (inject) begin
            frame_valid = 1'b1;
            frame_data  = nd;
            @(negedge clk);
            frame_valid = 1'b0;
          end
        end
      end
    end
    check(errs == 0, "R2 R3 R4 R5", $sformatf("frame %0h half %0d", d, first),
          first_act, ~first_act);
  endtask

  // Load from idle, then sample the whole frame.
  task automatic send_idle(input logic [63:0] d, input logic [1:0] sel);
    rate_sel = sel;
    @(negedge clk);
    check(frame_ready === 1'b1, "R10", "ready while idle", frame_ready, 1);
    frame_valid = 1'b1;
    frame_data  = d;
    @(negedge clk);
    frame_valid = 1'b0;
    // R7: nothing moves on the accepting edge
    check(line_out === lvl, "R7", "no toggle on accept edge", line_out, lvl);
    @(negedge clk);
    play_frame(d, halves_for(sel), 1'b0, '0, 1'b0, 2'b00);
    repeat (halves_for(sel)) @(negedge clk);
  endtask

  task automatic t_reset();
    check(line_out === 1'b0, "R1", "line after reset", line_out, 0);
    check(frame_ready === 1'b1, "R1", "ready after reset", frame_ready, 1);
  endtask

  task automatic t_rates();
    send_idle(64'h0123_4567_89AB_CDEF, 2'b10);   // R5 30 fps
    send_idle(64'h0000_0000_0000_0000, 2'b00);   // R5 24 fps, all zero
    send_idle(64'hFFFF_FFFF_FFFF_FFFF, 2'b01);   // R5 25 fps, all one
    send_idle(64'hA5A5_0F0F_3C3C_9669, 2'b11);   // R5 fallback code
  endtask

  task automatic t_idle_hold();
    logic held;
    held = line_out;
    repeat (200) @(negedge clk);
    check(line_out === held, "R10", "line held in idle", line_out, held);
    check(frame_ready === 1'b1, "R10", "ready held in idle", frame_ready, 1);
    send_idle(64'h1, 2'b10);                     // R9 first cell toggles held level
  endtask

  task automatic t_back_to_back();
    logic [63:0] a, b;
    a = 64'hDEAD_BEEF_0000_FFFF;
    b = 64'h8000_0000_0000_0001;
    rate_sel = 2'b10;
    @(negedge clk);
    frame_valid = 1'b1;
    frame_data  = a;
    @(negedge clk);
    frame_valid = 1'b0;
    @(negedge clk);
    play_frame(a, halves_for(2'b10), 1'b1, b, 1'b0, 2'b00);
    repeat (halves_for(2'b10)) @(negedge clk);
    // R8 R9: second frame begins at the end edge, continuing polarity
    play_frame(b, halves_for(2'b10), 1'b0, '0, 1'b0, 2'b00);
    repeat (halves_for(2'b10)) @(negedge clk);
    check(frame_ready === 1'b1, "R8", "ready after pair", frame_ready, 1);
  endtask

  task automatic t_rate_change();
    rate_sel = 2'b10;
    @(negedge clk);
    frame_valid = 1'b1;
    frame_data  = 64'h5555_AAAA_1234_8765;
    @(negedge clk);
    frame_valid = 1'b0;
    @(negedge clk);
    // R6: switch to 24 fps mid-frame; timing must stay at 30 fps
    play_frame(64'h5555_AAAA_1234_8765, halves_for(2'b10), 1'b0, '0, 1'b1, 2'b00);
    repeat (halves_for(2'b10)) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rates();
    t_idle_hold();
    t_back_to_back();
    t_rate_change();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end
endmodule